// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block runs the external bus of a small 8-bit controller core. A free-running phase counter splits every machine cycle into twelve oscillator periods. At the close of each machine cycle the block takes one request from the core: an idle slot, an instruction fetch, a data read or a data write. It then plays that request out on the pins during the following machine cycle.

The low byte of the address and the data share one 8-bit port. An address-latch strobe marks the address phase so that an outside latch can hold the low address byte. The high address byte goes out on a second port. Instruction fetches use an active-low program-store strobe, and data accesses use active-low read and write strobes. The block also decides whether each fetch is served by the internal code store or by the external bus. With the ROM enable high, program counter values below the ROM size stay internal. With the enable low, every fetch goes to the external bus.

For short indirect data accesses, the high address byte comes from the port-2 output latch rather than from the data pointer. Bytes read from the bus are captured and handed back to the core together with a one-clock valid pulse.

Top module: `ext_bus_sequencer`

## Requirements
- R1: `mc_phase` counts 0,1,…,11 and wraps to 0. A request on the request inputs is taken on the rising edge that ends phase 11 and is played out during phases 0 to 11 that follow. `cyc_kind` encoding: 0 idle, 1 fetch, 2 data read, 3 data write.
- R2: `ale` is high in phases 0 to 2 of an external bus cycle. It is low in every other phase and in idle and internal-fetch cycles.
- R3: In phases 0 to 3 of an external bus cycle, `port_lo_oe` is 1 and `port_lo_out` carries the low address byte.
- R4: In an external fetch, `psen_n` is low in phases 4 to 9 and the low port is released in phases 4 to 11. The value on `port_lo_in` at the edge ending phase 9 appears on `rdata`, with `rdata_valid` high during phase 10 only.
- R5: In a data read, `rd_n` is low in phases 5 to 10 and the low port is released in phases 4 to 11. The value on `port_lo_in` at the edge ending phase 10 appears on `rdata`, with `rdata_valid` high during phase 11 only.
- R6: In a data write, `wr_n` is low in phases 5 to 10. The low port is driven with the write byte in phases 4 to 11, so it covers the whole strobe window.
- R7: A fetch with `rom_en`=1 and `pc` below 4096 is internal. `fetch_internal` is 1 for that cycle, no strobe or `ale` pulses, the low port stays released and `rdata_valid` stays 0. A fetch at `pc`=4096 or above, or with `rom_en`=0, is external.
- R8: During an external cycle `port_hi_out` holds the high address byte for all twelve phases. A fetch uses `pc`, a data access with `ind8`=0 uses `dptr`, and one with `ind8`=1 uses `p2_latch` (low byte from `ri_addr`). In idle and internal cycles `port_hi_out` shows `p2_latch`.
- R9: `psen_n` is never low in the same clock as `rd_n` or `wr_n`.
- R10: While `rst_n` is low, `mc_phase` is 0, all strobes are high, and `ale`, `port_lo_oe` and `rdata_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | oscillator clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cyc_kind | input | 2 | request for next machine cycle |
| pc | input | 16 | fetch address |
| dptr | input | 16 | 16-bit data address |
| ri_addr | input | 8 | 8-bit indirect data address |
| ind8 | input | 1 | data access uses 8-bit indirect address |
| p2_latch | input | 8 | port-2 output latch value |
| wdata | input | 8 | byte to write |
| rom_en | input | 1 | internal code store enabled |
| port_lo_in | input | 8 | low port pin values |
| ale | output | 1 | address latch strobe |
| psen_n | output | 1 | program-store strobe, active low |
| rd_n | output | 1 | data read strobe, active low |
| wr_n | output | 1 | data write strobe, active low |
| port_lo_oe | output | 1 | low port output enable |
| port_lo_out | output | 8 | low port drive value |
| port_hi_out | output | 8 | high port drive value |
| rdata | output | 8 | byte captured from the bus |
| rdata_valid | output | 1 | one-clock pulse with new `rdata` |
| fetch_internal | output | 1 | current fetch served internally |
| mc_phase | output | 4 | phase within machine cycle |

## Verification
The bench aims at the ROM boundary: a fetch at 4095 with the enable high, one at 4096, and one at address 0 with the enable low. A design with an off-by-one compare, or one that ignores the enable, would pulse strobes on an internal fetch or stay silent on an external one. Indirect reads and writes with a port-2 value that differs from the data pointer's high byte expose a design that takes the wrong high-address source. The bench checks each phase of every cycle against windows it computes itself. A design that floats the port under the write strobe, drives it under a read, or captures the read byte one phase early or late therefore shows up as a wrong value in a named phase.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int MC_PHASES  = 12;
    localparam int PH_W       = $clog2(MC_PHASES);
    // phase windows inside one machine cycle
    localparam int ALE_LAST   = 2;
    localparam int ADDR_LAST  = 3;
    localparam int PSEN_FIRST = 4;
    localparam int PSEN_LAST  = 9;
    localparam int STB_FIRST  = 5;
    localparam int STB_LAST   = 10;

    typedef enum logic [1:0] {
        K_IDLE  = 2'b00,
        K_FETCH = 2'b01,
        K_READ  = 2'b10,
        K_WRITE = 2'b11
    } kind_e;

    typedef struct packed {
        kind_e               kind;
        logic                ext;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
    } req_t;
endpackage

// File: rtl/bus_phase_ctr.sv
module bus_phase_ctr
    import bus_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase_o,
    output logic            last_o
);
    localparam logic [PH_W-1:0] LAST = PH_W'(MC_PHASES - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d    = ctr_q;
        ctr_d.ph = (ctr_q.ph == LAST) ? '0 : ctr_q.ph + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign phase_o = ctr_q.ph;
    assign last_o  = (ctr_q.ph == LAST);

    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == LAST) |=> (phase_o == '0));
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != LAST) |=> (phase_o == $past(phase_o) + 1'b1));
endmodule

// File: rtl/bus_req_decode.sv
module bus_req_decode
    import bus_seq_pkg::*;
#(
    parameter int ROM_BYTES = 4096
) (
    input  kind_e             kind_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] dptr_i,
    input  logic [7:0]        ri_i,
    input  logic [7:0]        p2_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ind8_i,
    input  logic              rom_en_i,
    output req_t              req_o
);
    localparam logic [ADDR_W:0] ROM_LIM = (ADDR_W+1)'(ROM_BYTES);

    always_comb begin
        req_o       = '0;
        req_o.kind  = kind_i;
        req_o.wdata = wdata_i;
        unique case (kind_i)
            K_FETCH: begin
                req_o.addr = pc_i;
                req_o.ext  = !(rom_en_i && ({1'b0, pc_i} < ROM_LIM));
            end
            K_READ, K_WRITE: begin
                req_o.addr = ind8_i ? {p2_i, ri_i} : dptr_i;
                req_o.ext  = 1'b1;
            end
            default: begin
                req_o.addr = '0;
                req_o.ext  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import bus_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   phase_i,
    input  req_t              cur_i,
    output logic              ale_o,
    output logic              psen_n_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              lo_oe_o,
    output logic [DATA_W-1:0] lo_out_o,
    output logic              cap_o
);
    localparam logic [PH_W-1:0] P_ALE_L  = PH_W'(ALE_LAST);
    localparam logic [PH_W-1:0] P_ADR_L  = PH_W'(ADDR_LAST);
    localparam logic [PH_W-1:0] P_PSN_F  = PH_W'(PSEN_FIRST);
    localparam logic [PH_W-1:0] P_PSN_L  = PH_W'(PSEN_LAST);
    localparam logic [PH_W-1:0] P_STB_F  = PH_W'(STB_FIRST);
    localparam logic [PH_W-1:0] P_STB_L  = PH_W'(STB_LAST);

    logic in_addr, in_psen, in_stb;

    always_comb begin
        in_addr  = (phase_i <= P_ADR_L);
        in_psen  = (phase_i >= P_PSN_F) && (phase_i <= P_PSN_L);
        in_stb   = (phase_i >= P_STB_F) && (phase_i <= P_STB_L);
        ale_o    = cur_i.ext && (phase_i <= P_ALE_L);
        psen_n_o = !(cur_i.ext && cur_i.kind == K_FETCH && in_psen);
        rd_n_o   = !(cur_i.ext && cur_i.kind == K_READ  && in_stb);
        wr_n_o   = !(cur_i.ext && cur_i.kind == K_WRITE && in_stb);
        lo_oe_o  = cur_i.ext && (in_addr || cur_i.kind == K_WRITE);
        if (in_addr)                   lo_out_o = cur_i.addr[DATA_W-1:0];
        else if (cur_i.kind == K_WRITE) lo_out_o = cur_i.wdata;
        else                           lo_out_o = '0;
        cap_o    = cur_i.ext &&
                   ((cur_i.kind == K_FETCH && phase_i == P_PSN_L) ||
                    (cur_i.kind == K_READ  && phase_i == P_STB_L));
    end

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n_o |-> (rd_n_o && wr_n_o));
    p_ale_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |-> (psen_n_o && rd_n_o && wr_n_o));
    p_read_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n_o || !psen_n_o) |-> !lo_oe_o);
    p_write_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> lo_oe_o);
endmodule

// File: rtl/ext_bus_sequencer.sv
module ext_bus_sequencer
    import bus_seq_pkg::*;
#(
    parameter int ROM_BYTES = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cyc_kind,
    input  logic [15:0] pc,
    input  logic [15:0] dptr,
    input  logic [7:0]  ri_addr,
    input  logic        ind8,
    input  logic [7:0]  p2_latch,
    input  logic [7:0]  wdata,
    input  logic        rom_en,
    input  logic [7:0]  port_lo_in,
    output logic        ale,
    output logic        psen_n,
    output logic        rd_n,
    output logic        wr_n,
    output logic        port_lo_oe,
    output logic [7:0]  port_lo_out,
    output logic [7:0]  port_hi_out,
    output logic [7:0]  rdata,
    output logic        rdata_valid,
    output logic        fetch_internal,
    output logic [3:0]  mc_phase
);
    typedef struct packed {
        req_t              cur;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } seq_t;

    seq_t            seq_d, seq_q;
    req_t            nreq;
    logic [PH_W-1:0] phase;
    logic            last, cap;

    bus_phase_ctr u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase),
        .last_o  (last)
    );

    bus_req_decode #(.ROM_BYTES(ROM_BYTES)) u_dec (
        .kind_i   (kind_e'(cyc_kind)),
        .pc_i     (pc),
        .dptr_i   (dptr),
        .ri_i     (ri_addr),
        .p2_i     (p2_latch),
        .wdata_i  (wdata),
        .ind8_i   (ind8),
        .rom_en_i (rom_en),
        .req_o    (nreq)
    );

    bus_strobe_gen u_stb (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_i  (phase),
        .cur_i    (seq_q.cur),
        .ale_o    (ale),
        .psen_n_o (psen_n),
        .rd_n_o   (rd_n),
        .wr_n_o   (wr_n),
        .lo_oe_o  (port_lo_oe),
        .lo_out_o (port_lo_out),
        .cap_o    (cap)
    );

    always_comb begin
        seq_d        = seq_q;
        seq_d.rvalid = 1'b0;
        if (last) seq_d.cur = nreq;
        if (cap) begin
            seq_d.rdata  = port_lo_in;
            seq_d.rvalid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign port_hi_out    = seq_q.cur.ext ? seq_q.cur.addr[ADDR_W-1:DATA_W] : p2_latch;
    assign rdata          = seq_q.rdata;
    assign rdata_valid    = seq_q.rvalid;
    assign fetch_internal = (seq_q.cur.kind == K_FETCH) && !seq_q.cur.ext;
    assign mc_phase       = phase;

    p_hi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.cur.ext && !last) |=> $stable(port_hi_out));
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid);
    p_int_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_internal |-> (psen_n && !ale && !port_lo_oe));
endmodule

// File: tb/tb_ext_bus_sequencer.sv
`timescale 1ns/1ps
module tb_ext_bus_sequencer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cyc_kind;
    logic [15:0] pc, dptr;
    logic [7:0]  ri_addr, p2_latch, wdata, port_lo_in;
    logic        ind8, rom_en;
    logic        ale, psen_n, rd_n, wr_n, port_lo_oe, rdata_valid, fetch_internal;
    logic [7:0]  port_lo_out, port_hi_out, rdata;
    logic [3:0]  mc_phase;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ext_bus_sequencer dut (
        .clk(clk), .rst_n(rst_n), .cyc_kind(cyc_kind), .pc(pc), .dptr(dptr),
        .ri_addr(ri_addr), .ind8(ind8), .p2_latch(p2_latch), .wdata(wdata),
        .rom_en(rom_en), .port_lo_in(port_lo_in), .ale(ale), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .port_lo_oe(port_lo_oe), .port_lo_out(port_lo_out),
        .port_hi_out(port_hi_out), .rdata(rdata), .rdata_valid(rdata_valid),
        .fetch_internal(fetch_internal), .mc_phase(mc_phase)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic is_ext(input logic [1:0] k, input logic [15:0] a, input logic en);
        if (k == 2'd0) return 1'b0;
        if (k == 2'd1) return !(en && a < 16'd4096);
        return 1'b1;
    endfunction

    function automatic logic [15:0] exp_addr(input logic [1:0] k, input logic [15:0] a,
                                             input logic [15:0] d, input logic i8,
                                             input logic [7:0] p2, input logic [7:0] ri);
        if (k == 2'd1) return a;
        return i8 ? {p2, ri} : d;
    endfunction

    task automatic run_cycle(input logic [1:0] k, input logic [15:0] a, input logic [15:0] d,
                             input logic [7:0] ri, input logic i8, input logic [7:0] p2,
                             input logic [7:0] wd, input logic en, input logic [7:0] bus);
        logic        ext;
        logic [15:0] ad;
        cyc_kind = k; pc = a; dptr = d; ri_addr = ri; ind8 = i8;
        p2_latch = p2; wdata = wd; rom_en = en; port_lo_in = bus;
        ext = is_ext(k, a, en);
        ad  = exp_addr(k, a, d, i8, p2, ri);
        while (mc_phase != 4'd11) @(negedge clk);
        for (int p = 0; p < 12; p++) begin
            logic e_psen, e_rd, e_wr, e_oe, e_val;
            @(negedge clk);
            e_psen = ext && k == 2'd1 && p >= 4 && p <= 9;
            e_rd   = ext && k == 2'd2 && p >= 5 && p <= 10;
            e_wr   = ext && k == 2'd3 && p >= 5 && p <= 10;
            e_oe   = ext && (p <= 3 || k == 2'd3);
            e_val  = ext && ((k == 2'd1 && p == 10) || (k == 2'd2 && p == 11));
            chk("R1 phase", 32'(mc_phase), 32'(p));
            chk("R2 ale", 32'(ale), 32'(ext && p <= 2));
            chk("R4 psen_n", 32'(psen_n), 32'(!e_psen));
            chk("R5 rd_n", 32'(rd_n), 32'(!e_rd));
            chk("R6 wr_n", 32'(wr_n), 32'(!e_wr));
            chk(k == 2'd3 ? "R6 lo_oe" : "R4/R5 lo_oe", 32'(port_lo_oe), 32'(e_oe));
            if (e_oe && p <= 3) chk("R3 lo_out addr", 32'(port_lo_out), 32'(ad[7:0]));
            if (e_oe && p > 3)  chk("R6 lo_out data", 32'(port_lo_out), 32'(wd));
            chk("R8 hi_out", 32'(port_hi_out), 32'(ext ? ad[15:8] : p2));
            chk("R7 fetch_internal", 32'(fetch_internal), 32'(k == 2'd1 && !ext));
            chk(k == 2'd2 ? "R5 rdata_valid" : "R4 rdata_valid", 32'(rdata_valid), 32'(e_val));
            if (e_val) chk("R4/R5 rdata", 32'(rdata), 32'(bus));
            chk("R9 exclusive", 32'(!psen_n && (!rd_n || !wr_n)), 32'd0);
        end
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; cyc_kind = 2'd0; pc = '0; dptr = '0; ri_addr = '0; ind8 = 1'b0;
        p2_latch = 8'hA5; wdata = '0; rom_en = 1'b1; port_lo_in = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 phase", 32'(mc_phase), 32'd0);
        chk("R10 strobes", 32'({psen_n, rd_n, wr_n}), 32'h7);
        chk("R10 ale/oe/valid", 32'({ale, port_lo_oe, rdata_valid}), 32'd0);
        rst_n = 1'b1;
        // directed corners: R7 boundary and enable
        run_cycle(2'd1, 16'd4095, 16'h0, 8'h0, 1'b0, 8'h3C, 8'h0, 1'b1, 8'h11);
        run_cycle(2'd1, 16'd4096, 16'h0, 8'h0, 1'b0, 8'h3C, 8'h0, 1'b1, 8'h22);
        run_cycle(2'd1, 16'd0,    16'h0, 8'h0, 1'b0, 8'h3C, 8'h0, 1'b0, 8'h33);
        // R8 indirect vs pointer sources
        run_cycle(2'd2, 16'h0, 16'hBEEF, 8'h47, 1'b1, 8'h9A, 8'h0, 1'b1, 8'h5C);
        run_cycle(2'd2, 16'h0, 16'hBEEF, 8'h47, 1'b0, 8'h9A, 8'h0, 1'b1, 8'h6D);
        run_cycle(2'd3, 16'h0, 16'h1234, 8'hE1, 1'b1, 8'h7E, 8'hC3, 1'b1, 8'h00);
        run_cycle(2'd3, 16'h0, 16'h1234, 8'hE1, 1'b0, 8'h7E, 8'h96, 1'b1, 8'h00);
        run_cycle(2'd0, 16'h0, 16'h0, 8'h0, 1'b0, 8'h81, 8'h0, 1'b1, 8'hFF);
        // constrained random mix
        for (int i = 0; i < 80; i++) begin
            logic [15:0] a;
            a = ($urandom % 2 == 0) ? 16'($urandom) : 16'(4090 + $urandom % 12);
            run_cycle(2'($urandom), a, 16'($urandom), 8'($urandom), 1'($urandom),
                      8'($urandom), 8'($urandom), 1'($urandom), 8'($urandom));
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule